// File: doc/BRIEF.md
# Ring-Oscillator XOR Entropy Sampler

The block takes N free-running oscillator signals, which have no timing relation to any clock in the chip, and turns them into a raw random bit stream. At every sampling edge it produces one bit equal to the parity of the oscillator levels. It packs these bits into 16-bit words for a host-side data path. The bits are not post-processed. Health testing and entropy estimation are left to the consumer.

Two choices are fixed at compile time.

- The combiner style. In the direct style, the parity of the raw asynchronous inputs feeds one sampling flip-flop. In the pre-registered style, every oscillator first passes through its own sampling flip-flop, and the parity of those registered levels is sampled once more. This adds exactly one sample of latency and leaves the bit sequence otherwise unchanged.
- The sampling clock. It is either an external reference clock (nominally 32 MHz) or a dedicated oscillator input divided by eight. With the divided source, any slow disturbance common to all oscillators also moves the sampling instants.

An enable input pauses sampling without losing a partly assembled word. An asynchronous active-low reset clears everything. Its release is synchronised into each clock domain.

Top module: `ro_xor_sampler`

## Requirements
- R1: Each enabled sampling edge captures one raw bit equal to the XOR of all N oscillator inputs at that edge.
- R2: Words are packed least significant bit first: bit 0 of a word holds the oldest of its 16 raw bits and bit 15 the newest.
- R3: `word_vld_o` is high for exactly one sampling-clock cycle after every 16th raw bit enters the packer. `word_o` changes only together with a strobe and otherwise holds its value.
- R4: In pre-registered mode each oscillator is captured by its own flip-flop before the XOR. The raw bit stream is identical to direct mode but delayed by one sampling edge.
- R5: Reset behaves as follows:
  - While `rst_n_i` is low, `word_o` reads 0 and `word_vld_o` reads 0, and this takes effect at once, without waiting for a clock.
  - After release, the internal reset is held for 2 sampling edges.
  - With enable high, the first strobe follows the 19th sampling edge after release in direct mode and the 20th in pre-registered mode.
- R6: While `en_i` is low at a sampling edge, no sample is taken, no strobe occurs, and the partial word, bit count and `word_o` all keep their values. Packing resumes where it stopped.
- R7: In divided-clock mode the sampling clock is `osc_ref_i` divided by 8, so strobes are spaced exactly 128 `osc_ref_i` cycles apart.
- R8: In divided-clock mode, constant oscillator inputs give words of all ones when an odd number of inputs is high and all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | External sampling reference clock (used in external-clock mode) |
| osc_ref_i | input | 1 | Dedicated oscillator divided down for the sampling clock (used in divided mode) |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sampling enable, synchronous to the sampling clock |
| ring_i | input | N_RING | Asynchronous free-running oscillator levels |
| word_o | output | WORD_W | Last completed packed word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The assertions check the following on every sampling-clock cycle:
- the strobe lasts one cycle;
- the word never changes without a strobe;
- a low enable suppresses the strobe and freezes the word.

The remaining behaviours can only be shown by the bench's scenarios:
- the parity value of each bit and its position in the word;
- the one-sample shift between the two combiner styles;
- the latency of the first word after reset;
- the strobe spacing and word contents under the divided oscillator clock.

The bench compares two external-clock instances against a behavioural sample-history model. It drives the oscillator inputs with jittered toggle patterns.

// File: rtl/ro_pkg.sv
package ro_pkg;
  typedef enum logic {
    COMB_DIRECT = 1'b0,
    COMB_PREREG = 1'b1
  } comb_mode_e;

  typedef enum logic {
    SCLK_EXTERNAL = 1'b0,
    SCLK_DIVIDED  = 1'b1
  } sclk_src_e;
endpackage

// File: rtl/ro_rst_sync.sv
module ro_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ro_clk_div.sv
module ro_clk_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic osc_i,
  input  logic arst_n_i,
  output logic clk_o
);
  logic              osc_rst_n;
  logic [DIV_LOG2-1:0] cnt_q;
  logic [DIV_LOG2-1:0] cnt_d;

  ro_rst_sync #(.STAGES(2)) u_osc_rst (
    .clk_i    (osc_i),
    .arst_n_i (arst_n_i),
    .srst_n_o (osc_rst_n)
  );

  always_comb begin
    cnt_d = cnt_q + DIV_LOG2'(1);
  end

  always_ff @(posedge osc_i or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Counter MSB: 50% duty square wave at osc / 2**DIV_LOG2
  assign clk_o = cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/ro_combiner.sv
module ro_combiner #(
  parameter int                 N_RING = 8,
  parameter ro_pkg::comb_mode_e MODE   = ro_pkg::COMB_DIRECT
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [N_RING-1:0] ring_i,
  output logic              bit_o,
  output logic              bit_vld_o
);
  logic xor_val;
  logic xor_vld;
  logic raw_q, raw_d;
  logic vld_q, vld_d;

  if (MODE == ro_pkg::COMB_PREREG) begin : g_prereg
    logic [N_RING-1:0] stage_q, stage_d;
    logic              stage_vld_q, stage_vld_d;

    always_comb begin
      stage_d     = stage_q;
      stage_vld_d = stage_vld_q;
      if (en_i) begin
        stage_d     = ring_i;
        stage_vld_d = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stage_q     <= '0;
        stage_vld_q <= 1'b0;
      end else begin
        stage_q     <= stage_d;
        stage_vld_q <= stage_vld_d;
      end
    end

    assign xor_val = ^stage_q;
    assign xor_vld = stage_vld_q;
  end else begin : g_direct
    // Parity of asynchronous levels goes straight to the sampling flop
    assign xor_val = ^ring_i;
    assign xor_vld = 1'b1;
  end

  always_comb begin
    raw_d = raw_q;
    vld_d = vld_q;
    if (en_i) begin
      raw_d = xor_val;
      vld_d = xor_vld;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      raw_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o     = raw_q;
  assign bit_vld_o = vld_q;
endmodule

// File: rtl/ro_word_packer.sv
module ro_word_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic              shift;
  logic [WORD_W-1:0] sh_next;

  assign shift   = en_i & bit_vld_i;
  assign sh_next = {bit_i, sh_q[WORD_W-1:1]};

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (shift) begin
      sh_d = sh_next;
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        word_d = sh_next;
        vld_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q   <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/ro_xor_sampler.sv
module ro_xor_sampler #(
  parameter int                 N_RING   = 8,
  parameter int                 WORD_W   = 16,
  parameter int                 DIV_LOG2 = 3,
  parameter ro_pkg::comb_mode_e MODE     = ro_pkg::COMB_DIRECT,
  parameter ro_pkg::sclk_src_e  CLK_SRC  = ro_pkg::SCLK_EXTERNAL
) (
  input  logic              clk_ref_i,
  input  logic              osc_ref_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [N_RING-1:0] ring_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic samp_clk;
  logic samp_rst_n;
  logic raw_bit;
  logic raw_vld;

  if (CLK_SRC == ro_pkg::SCLK_DIVIDED) begin : g_int_clk
    logic unused_clk_ref;
    assign unused_clk_ref = clk_ref_i;
    ro_clk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .osc_i    (osc_ref_i),
      .arst_n_i (rst_n_i),
      .clk_o    (samp_clk)
    );
  end else begin : g_ext_clk
    logic unused_osc_ref;
    assign unused_osc_ref = osc_ref_i;
    assign samp_clk = clk_ref_i;
  end

  ro_rst_sync #(.STAGES(2)) u_samp_rst (
    .clk_i    (samp_clk),
    .arst_n_i (rst_n_i),
    .srst_n_o (samp_rst_n)
  );

  ro_combiner #(.N_RING(N_RING), .MODE(MODE)) u_comb (
    .clk_i     (samp_clk),
    .rst_n_i   (samp_rst_n),
    .en_i      (en_i),
    .ring_i    (ring_i),
    .bit_o     (raw_bit),
    .bit_vld_o (raw_vld)
  );

  ro_word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i      (samp_clk),
    .rst_n_i    (samp_rst_n),
    .en_i       (en_i),
    .bit_i      (raw_bit),
    .bit_vld_i  (raw_vld),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );
endmodule

// File: rtl/ro_xor_sampler_chk.sv
module ro_xor_sampler_chk #(
  parameter int WORD_W = 16
) (
  input logic              samp_clk,
  input logic              samp_rst_n,
  input logic              en_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o
);
  // R3
  strobe_single_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    word_vld_o |=> !word_vld_o);

  // R3
  word_hold_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    !$stable(word_o) |-> word_vld_o);

  // R6
  en_low_no_strobe_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    !en_i |=> !word_vld_o);

  // R6
  en_low_word_frozen_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    !en_i |=> $stable(word_o));
endmodule

bind ro_xor_sampler ro_xor_sampler_chk #(.WORD_W(WORD_W)) u_chk (
  .samp_clk   (samp_clk),
  .samp_rst_n (samp_rst_n),
  .en_i       (en_i),
  .word_o     (word_o),
  .word_vld_o (word_vld_o)
);

// File: tb/ro_xor_sampler_tb.sv
`timescale 1ns/1ps
module ro_xor_sampler_tb;
  localparam real CLK_PERIOD = 10.0;
  localparam real OSC_HALF   = CLK_PERIOD / 16.0;
  localparam int  N          = 8;
  localparam int  NC         = 4;
  localparam int  W          = 16;

  logic clk, osc, rst_n, en;
  logic [N-1:0]  ring;
  logic [NC-1:0] ring_c;
  logic [W-1:0]  w_a, w_b, w_c;
  logic          v_a, v_b, v_c;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  ro_xor_sampler #(.N_RING(N), .WORD_W(W), .MODE(ro_pkg::COMB_DIRECT),
                   .CLK_SRC(ro_pkg::SCLK_EXTERNAL)) u_dut (
    .clk_ref_i(clk), .osc_ref_i(1'b0), .rst_n_i(rst_n), .en_i(en),
    .ring_i(ring), .word_o(w_a), .word_vld_o(v_a));

  ro_xor_sampler #(.N_RING(N), .WORD_W(W), .MODE(ro_pkg::COMB_PREREG),
                   .CLK_SRC(ro_pkg::SCLK_EXTERNAL)) u_dut_pre (
    .clk_ref_i(clk), .osc_ref_i(1'b0), .rst_n_i(rst_n), .en_i(en),
    .ring_i(ring), .word_o(w_b), .word_vld_o(v_b));

  ro_xor_sampler #(.N_RING(NC), .WORD_W(W), .MODE(ro_pkg::COMB_PREREG),
                   .CLK_SRC(ro_pkg::SCLK_DIVIDED)) u_dut_int (
    .clk_ref_i(clk), .osc_ref_i(osc), .rst_n_i(rst_n), .en_i(1'b1),
    .ring_i(ring_c), .word_o(w_c), .word_vld_o(v_c));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2.0) clk = ~clk;
  end

  initial begin
    osc = 1'b0;
    #0.3;
    forever #(OSC_HALF) osc = ~osc;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of sampled parities, one per enabled edge
  bit          hist[$];
  int          nsamp = 0;
  int          rel   = 0;
  logic        ev [2];
  logic [W-1:0] ew [2];

  initial begin
    ev[0] = 1'b0; ev[1] = 1'b0; ew[0] = '0; ew[1] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; nsamp = 0; hist.delete();
      ev[0] = 1'b0; ev[1] = 1'b0; ew[0] = '0; ew[1] = '0;
    end else if (rel < 2) begin
      rel = rel + 1;
    end else begin
      ev[0] = 1'b0; ev[1] = 1'b0;
      if (en) begin
        hist.push_back(^ring);
        nsamp = nsamp + 1;
        for (int m = 0; m < 2; m++) begin
          int lat;
          int c;
          lat = m + 1;
          if (nsamp - 1 >= lat) begin
            c = nsamp - 1 - lat;
            if (c % W == W - 1) begin
              for (int i = 0; i < W; i++) ew[m][i] = hist[c-(W-1)+i];
              ev[m] = 1'b1;
            end
          end
        end
      end
    end
  end

  task automatic compare();
    chk(v_a == ev[0], "R3", "direct strobe", 32'(v_a), 32'(ev[0]));
    chk(w_a == ew[0], tag,  "direct word (R1 R2)", 32'(w_a), 32'(ew[0]));
    chk(v_b == ev[1], "R4", "prereg strobe", 32'(v_b), 32'(ev[1]));
    chk(w_b == ew[1], "R4", "prereg word", 32'(w_b), 32'(ew[1]));
  endtask

  // Ring stimulus: jittery free-running toggles
  logic [15:0] lfsr = 16'hACE1;
  int ph  [N];
  int per [N];
  initial for (int j = 0; j < N; j++) begin ph[j] = 0; per[j] = 3 + 2*j; end

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic drive(input int mode, input int k);
    lfsr = lfsr_next(lfsr);
    case (mode)
      0: ring = '0;
      1: ring = '1;
      2: ring = N'(1) << (k % N);
      3: for (int j = 0; j < N; j++) begin
           ph[j] = ph[j] + 1;
           if (ph[j] >= per[j] + int'(lfsr[j % 16] & lfsr[(j+5) % 16])) begin
             ring[j] = ~ring[j];
             ph[j] = 0;
           end
         end
      default: ring = lfsr[N-1:0] ^ lfsr[15:16-N];
    endcase
  endtask

  task automatic run(input int mode, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      compare();
      drive(mode, k);
    end
  endtask

  // Divided-clock instance monitor
  int   osc_cnt = 0;
  int   last_strobe = 0;
  bit   have_prev = 1'b0;
  int   int_seen = 0;
  logic [W-1:0] int_exp = 16'hFFFF;
  logic v_c_prev = 1'b0;

  always @(posedge osc) osc_cnt = osc_cnt + 1;

  always @(negedge osc) begin
    if (rst_n && v_c && !v_c_prev) begin
      if (have_prev)
        chk(osc_cnt - last_strobe == 128, "R7", "divided strobe spacing",
            32'(osc_cnt - last_strobe), 32'd128);
      if (int_seen >= 2)
        chk(w_c == int_exp, "R8", "divided word for constant rings", 32'(w_c), 32'(int_exp));
      last_strobe = osc_cnt;
      have_prev = 1'b1;
      int_seen = int_seen + 1;
    end
    v_c_prev = v_c;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first_a;
    int first_b;
    rst_n = 1'b0; en = 1'b1; ring = '0; ring_c = 4'b0111;
    repeat (4) @(negedge clk);
    // R5 reset state
    chk(w_a == '0 && !v_a, "R5", "direct outputs in reset", {15'd0, v_a, w_a}, 32'd0);
    chk(w_b == '0 && !v_b, "R5", "prereg outputs in reset", {15'd0, v_b, w_b}, 32'd0);
    rst_n = 1'b1;

    // R5 first-word latency
    first_a = 0; first_b = 0;
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      compare();
      if (v_a && first_a == 0) first_a = n;
      if (v_b && first_b == 0) first_b = n;
      drive(4, n);
    end
    chk(first_a == 19, "R5", "direct first strobe edge", 32'(first_a), 32'd19);
    chk(first_b == 20, "R5", "prereg first strobe edge", 32'(first_b), 32'd20);

    tag = "R1"; run(0, 40); run(1, 40); run(2, 64);
    tag = "R2"; run(3, 600);

    // R6 enable low mid-word
    tag = "R6";
    run(4, 7);
    en = 1'b0;
    run(4, 37);
    en = 1'b1;
    run(4, 50);
    en = 1'b0;
    run(3, 20);
    en = 1'b1;

    // Divided instance: switch to even parity pattern
    ring_c = 4'b0101; int_exp = 16'h0000; int_seen = 0;
    tag = "R1"; run(4, 800);

    // R5 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(w_a == '0 && !v_a, "R5", "direct async clear", {15'd0, v_a, w_a}, 32'd0);
    chk(w_b == '0 && !v_b, "R5", "prereg async clear", {15'd0, v_b, w_b}, 32'd0);
    have_prev = 1'b0; int_seen = 0; ring_c = 4'b1101; int_exp = 16'hFFFF;
    tag = "R5"; run(1, 5);
    rst_n = 1'b1;
    tag = "R2"; run(3, 900);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule